// File: doc/BRIEF.md
# Class-Level Grant Arbiter with Extended Grant Windows

This block is the second arbitration stage in front of a memory controller. Each of three traffic classes has already chosen its own winning thread. Every cycle the block looks at the three class winners and issues one registered grant per transaction. Class 0 is the urgent class and always wins. Classes 1 and 2 share the remaining bandwidth through a preference counter. The favoured class keeps priority for a programmed number of grants, and then preference passes to the other class.

An extended-grant window lets a class keep the grant for up to 1 to 3 back-to-back transactions. This keeps accesses that are likely to hit the same memory page together. A class keeps the window only while it goes on requesting and marks its request as a continuation. Pieces of a split transaction are granted normally, but they neither open the window nor use up its count. A window that is interrupted by a split piece therefore resumes from the count it had left. The preference counter holds its swap until the favoured class's window stops continuing.

Top module: `class_grant_arb`

## Requirements
- R1: Reset is synchronous and active high. After reset, `grant_vld` is 0, no window is open, class 1 is the favoured class of the 1/2 pair, and the preference counter holds `share_period`.
- R2: The grant is registered. A sampled cycle with any `req` bit set gives `grant_vld`=1 after the next clock edge, and the granted class is one that requested. A cycle with no request gives `grant_vld`=0 and closes any open window.
- R3: Whenever `req[0]` is set, the next grant goes to class 0, even while class 1 or class 2 holds a window.
- R4: A non-split grant to class c that does not continue a window opens a window of `eg_cfg[2c+1:2c]` transactions, with the value 0 treated as 1. Class c is then granted again, ahead of the preference order, on each cycle where `req[c]` and `cont[c]` are both set, until that many non-split grants have been made.
- R5: When the window holder drops `req` or `cont` for a cycle, the window gives way at once. That cycle is arbitrated by normal priority, and a non-split grant to another class opens that class's own window.
- R6: A grant to a class whose `split` bit is set leaves the window owner and its remaining count unchanged. A split grant opens no window, and a window interleaved with split grants resumes from the count it had left.
- R7: Each grant to the favoured class of the 1/2 pair counts down the preference counter. Once the counter is at 0, preference swaps to the other class and the counter reloads `share_period`, with 0 treated as 1. The swap waits while the favoured class is continuing its window. The swap takes effect for the grant decided in that same cycle.
- R8: `grant_cls` encodes class 0, 1 and 2 as the values 0, 1 and 2, and never shows 3 while `grant_vld` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 3 | Request of each class winner, bit c for class c |
| cont | input | 3 | Continuation (second-service) flag of each class winner |
| split | input | 3 | Each class winner's current transaction is a split piece |
| eg_cfg | input | 3*EGW | Window length per class, bits [2c+1:2c] for class c |
| share_period | input | SHW | Grants to the favoured class of the 1/2 pair before preference swaps |
| grant_vld | output | 1 | A transaction was granted |
| grant_cls | output | 2 | Class that received the grant |

## Verification
The assertions assume that `req` is known in every cycle after reset, and that the configuration inputs change only while reset is held. The stimulus drives all inputs at the falling edge. It reprograms `eg_cfg` only inside a reset pulse. It holds `share_period` at 2, so preference swaps occur within short directed sequences. These sequences cover overrides, idle hand-over, split interleaving and window expiry, and the expected grant sequence of each is written out by hand in the bench.

// File: rtl/carb_pkg.sv
package carb_pkg;
  localparam int NCLS = 3;
  typedef logic [1:0] cls_t;
  localparam cls_t CLS0 = 2'd0;
  localparam cls_t CLS1 = 2'd1;
  localparam cls_t CLS2 = 2'd2;

  function automatic cls_t pair_other(input cls_t c);
    return (c == CLS1) ? CLS2 : CLS1;
  endfunction
endpackage

// File: rtl/carb_pick.sv
module carb_pick
  import carb_pkg::*;
(
  input  logic [NCLS-1:0] req,
  input  logic            hold,
  input  cls_t            own,
  input  cls_t            fav,
  output logic            any,
  output cls_t            pick
);
  cls_t oth;

  always_comb begin
    oth = pair_other(fav);
    any = |req;
    if (hold)                pick = own;
    else if (req[CLS0])      pick = CLS0;
    else if (req[fav])       pick = fav;
    else if (req[oth])       pick = oth;
    else                     pick = CLS0;
  end
endmodule

// File: rtl/carb_window.sv
module carb_window
  import carb_pkg::*;
#(
  parameter int EGW = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NCLS-1:0] req,
  input  logic [NCLS-1:0] cont,
  input  logic            fire,
  input  cls_t            pick,
  input  logic            pick_split,
  input  logic [EGW-1:0]  pick_len,
  output logic            hold,
  output cls_t            own,
  output logic [EGW-1:0]  left
);
  logic           own_vld;
  logic           open_w;
  logic [EGW-1:0] len_eff;

  always_comb begin
    open_w  = own_vld && (left != '0);
    hold    = open_w && req[own] && cont[own] && !(req[CLS0] && (own != CLS0));
    len_eff = (pick_len == '0) ? EGW'(1) : pick_len;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      own_vld <= 1'b0;
      own     <= CLS0;
      left    <= '0;
    end else if (!fire) begin
      own_vld <= 1'b0;
      left    <= '0;
    end else if (pick_split) begin
      own_vld <= own_vld;
    end else if (hold) begin
      left    <= left - 1'b1;
    end else begin
      own_vld <= 1'b1;
      own     <= pick;
      left    <= len_eff - 1'b1;
    end
  end
endmodule

// File: rtl/carb_share.sv
module carb_share
  import carb_pkg::*;
#(
  parameter int SHW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [SHW-1:0] period,
  input  logic           fire,
  input  cls_t           pick,
  input  logic           hold,
  input  cls_t           own,
  output cls_t           fav_eff
);
  cls_t           fav;
  logic [SHW-1:0] cnt;
  logic [SHW-1:0] per_eff;
  logic           swap;

  always_comb begin
    per_eff = (period == '0) ? SHW'(1) : period;
    swap    = (cnt == '0) && !(hold && (own == fav));
    fav_eff = swap ? pair_other(fav) : fav;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fav <= CLS1;
      cnt <= per_eff;
    end else if (swap) begin
      fav <= pair_other(fav);
      cnt <= (fire && (pick == pair_other(fav))) ? per_eff - 1'b1 : per_eff;
    end else if (fire && (pick == fav) && (cnt != '0)) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/class_grant_arb.sv
module class_grant_arb
  import carb_pkg::*;
#(
  parameter int EGW = 2,
  parameter int SHW = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [2:0]          req,
  input  logic [2:0]          cont,
  input  logic [2:0]          split,
  input  logic [3*EGW-1:0]    eg_cfg,
  input  logic [SHW-1:0]      share_period,
  output logic                grant_vld,
  output logic [1:0]          grant_cls
);
  logic [EGW-1:0] len_arr [NCLS];
  logic           any;
  logic           hold;
  cls_t           pick;
  cls_t           own;
  cls_t           fav_eff;
  logic [EGW-1:0] win_left;

  for (genvar c = 0; c < NCLS; c++) begin : g_cfg
    assign len_arr[c] = eg_cfg[c*EGW +: EGW];
  end

  carb_pick u_pick (
    .req(req), .hold(hold), .own(own), .fav(fav_eff), .any(any), .pick(pick)
  );

  carb_window #(.EGW(EGW)) u_win (
    .clk(clk), .rst(rst), .req(req), .cont(cont), .fire(any), .pick(pick),
    .pick_split(split[pick]), .pick_len(len_arr[pick]),
    .hold(hold), .own(own), .left(win_left)
  );

  carb_share #(.SHW(SHW)) u_share (
    .clk(clk), .rst(rst), .period(share_period), .fire(any), .pick(pick),
    .hold(hold), .own(own), .fav_eff(fav_eff)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_vld <= 1'b0;
      grant_cls <= CLS0;
    end else begin
      grant_vld <= any;
      grant_cls <= any ? pick : CLS0;
    end
  end
endmodule

// File: rtl/class_grant_arb_chk.sv
module class_grant_arb_chk #(
  parameter int EGW = 2
) (
  input logic           clk,
  input logic           rst,
  input logic [2:0]     req,
  input logic           grant_vld,
  input logic [1:0]     grant_cls,
  input logic [EGW-1:0] win_left
);
  logic [2:0] req_q;
  always_ff @(posedge clk) req_q <= req;

  // R2
  idle_nogrant_chk: assert property (@(posedge clk) disable iff (rst)
    !(|req) |=> !grant_vld);
  // R2
  req_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (|req) |=> grant_vld);
  // R2
  granted_requested_chk: assert property (@(posedge clk) disable iff (rst)
    grant_vld |-> req_q[grant_cls]);
  // R3
  cls0_wins_chk: assert property (@(posedge clk) disable iff (rst)
    req[0] |=> (grant_vld && grant_cls == 2'd0));
  // R8
  cls_range_chk: assert property (@(posedge clk) disable iff (rst)
    grant_vld |-> (grant_cls != 2'd3));
  // R4
  win_bound_chk: assert property (@(posedge clk) disable iff (rst)
    win_left != '1);
endmodule

bind class_grant_arb class_grant_arb_chk #(.EGW(EGW)) u_chk (
  .clk(clk), .rst(rst), .req(req), .grant_vld(grant_vld),
  .grant_cls(grant_cls), .win_left(win_left)
);

// File: tb/class_grant_arb_test.sv
module class_grant_arb_test;
  localparam int CLK_PER = 10;
  localparam int EGW = 2;
  localparam int SHW = 4;

  typedef struct {
    logic       vld;
    logic [1:0] cls;
    string      tag;
  } exp_t;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [2:0]       req = '0, cont = '0, split = '0;
  logic [3*EGW-1:0] eg_cfg = {2'd2, 2'd3, 2'd1};
  logic [SHW-1:0]   share_period = 4'd2;
  logic             grant_vld;
  logic [1:0]       grant_cls;

  exp_t q[$];
  int   n_chk = 0;
  int   n_err = 0;
  bit   done = 0;

  always #(CLK_PER/2) clk = ~clk;

  class_grant_arb #(.EGW(EGW), .SHW(SHW)) uut (
    .clk(clk), .rst(rst), .req(req), .cont(cont), .split(split),
    .eg_cfg(eg_cfg), .share_period(share_period),
    .grant_vld(grant_vld), .grant_cls(grant_cls)
  );

  // monitor: compare a quarter period after each rising edge
  always @(posedge clk) begin
    #(CLK_PER/4);
    if (q.size() != 0) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (grant_vld !== e.vld || (e.vld && grant_cls !== e.cls)) begin
        n_err++;
        $display("FAIL %s: got vld=%0b cls=%0d, expected vld=%0b cls=%0d",
                 e.tag, grant_vld, grant_cls, e.vld, e.cls);
      end
    end
  end

  task automatic step(input logic [2:0] r, input logic [2:0] c,
                      input logic [2:0] s, input logic ev,
                      input logic [1:0] ec, input string tag);
    exp_t e;
    @(negedge clk);
    req = r; cont = c; split = s;
    e.vld = ev; e.cls = ec; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic do_reset(input logic [3*EGW-1:0] cfg);
    @(negedge clk);
    rst = 1'b1; req = '0; cont = '0; split = '0; eg_cfg = cfg;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(CLK_PER*5000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    // R1: reset state, no grant
    do_reset({2'd2, 2'd3, 2'd1});
    step(3'b000, 3'b000, 3'b000, 1'b0, 2'd0, "R1 reset idle");

    // R4 R7: class 1 window of 3, share swap waits, then class 2 window of 2
    step(3'b110, 3'b110, 3'b000, 1'b1, 2'd1, "R7 fav class1 first");
    step(3'b110, 3'b110, 3'b000, 1'b1, 2'd1, "R4 window 2nd");
    step(3'b110, 3'b110, 3'b000, 1'b1, 2'd1, "R4 window 3rd swap held");
    step(3'b110, 3'b110, 3'b000, 1'b1, 2'd2, "R7 swap to class2");
    step(3'b110, 3'b110, 3'b000, 1'b1, 2'd2, "R4 class2 window 2nd");
    step(3'b110, 3'b110, 3'b000, 1'b1, 2'd1, "R7 swap back to class1");
    step(3'b000, 3'b000, 3'b000, 1'b0, 2'd0, "R2 no request no grant");

    // R3: class 0 breaks class 1 window, R5 window restarts fresh
    do_reset({2'd2, 2'd3, 2'd1});
    step(3'b010, 3'b010, 3'b000, 1'b1, 2'd1, "R2 single requester");
    step(3'b011, 3'b010, 3'b000, 1'b1, 2'd0, "R3 class0 overrides window");
    step(3'b010, 3'b010, 3'b000, 1'b1, 2'd1, "R3 class1 after override");

    // R5: idle holder hands over, new holder keeps its window
    do_reset({2'd2, 2'd3, 2'd1});
    step(3'b110, 3'b110, 3'b000, 1'b1, 2'd1, "R5 class1 opens");
    step(3'b100, 3'b100, 3'b000, 1'b1, 2'd2, "R5 idle handover to class2");
    step(3'b110, 3'b110, 3'b000, 1'b1, 2'd2, "R5 class2 holds over fav");
    step(3'b110, 3'b110, 3'b000, 1'b1, 2'd1, "R5 class2 window done");

    // R5 R7: continuation flag low gives no hold, swap proceeds
    do_reset({2'd2, 2'd3, 2'd1});
    step(3'b110, 3'b000, 3'b000, 1'b1, 2'd1, "R5 cont low first");
    step(3'b110, 3'b000, 3'b000, 1'b1, 2'd1, "R5 cont low fav again");
    step(3'b110, 3'b000, 3'b000, 1'b1, 2'd2, "R7 swap not blocked");

    // R6: own split piece does not consume the window
    do_reset({2'd2, 2'd3, 2'd1});
    step(3'b010, 3'b010, 3'b000, 1'b1, 2'd1, "R6 open window");
    step(3'b010, 3'b010, 3'b010, 1'b1, 2'd1, "R6 split piece");
    step(3'b010, 3'b010, 3'b000, 1'b1, 2'd1, "R6 window 2nd");
    step(3'b110, 3'b110, 3'b000, 1'b1, 2'd1, "R6 window 3rd after split");
    step(3'b110, 3'b110, 3'b000, 1'b1, 2'd2, "R6 window over");

    // R6: split grant opens no window
    do_reset({2'd2, 2'd3, 2'd1});
    step(3'b100, 3'b100, 3'b100, 1'b1, 2'd2, "R6 split class2");
    step(3'b110, 3'b110, 3'b000, 1'b1, 2'd1, "R6 no window from split");

    // R6 R3: class 0 split interleaved, class 1 window resumes
    do_reset({2'd2, 2'd3, 2'd1});
    step(3'b010, 3'b010, 3'b000, 1'b1, 2'd1, "R6 open class1");
    step(3'b011, 3'b010, 3'b001, 1'b1, 2'd0, "R3 class0 split interleave");
    step(3'b010, 3'b010, 3'b000, 1'b1, 2'd1, "R6 resume 2nd");
    step(3'b110, 3'b110, 3'b000, 1'b1, 2'd1, "R6 resume 3rd");
    step(3'b110, 3'b110, 3'b000, 1'b1, 2'd2, "R6 resumed window ends");

    // R4: window length 1 for class 1, R8 class encoding
    do_reset({2'd2, 2'd1, 2'd1});
    step(3'b110, 3'b110, 3'b000, 1'b1, 2'd1, "R4 len1 grant");
    step(3'b110, 3'b110, 3'b000, 1'b1, 2'd1, "R7 fav again");
    step(3'b110, 3'b110, 3'b000, 1'b1, 2'd2, "R8 class2 code");
    step(3'b110, 3'b110, 3'b000, 1'b1, 2'd2, "R4 class2 window");
    step(3'b110, 3'b110, 3'b000, 1'b1, 2'd1, "R7 back to class1");
    step(3'b000, 3'b000, 3'b000, 1'b0, 2'd0, "R2 idle end");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule